// File: doc/BRIEF.md
# Banked GPIO Register Block

This block is a memory-mapped general-purpose I/O controller that serves several banks of 32 pins. Each bank holds an output data register, a direction register and an output-enable register, and it presents the live level of its input pins through a read-only register. A pin is driven only when it is set as an output and its output enable is also set. Otherwise the pad is left tristated.

The output data can be written in two ways. The first is a plain 32-bit write. The second goes through two maskable-write registers per bank, one for each 16-bit half. In a maskable write the upper 16 bits of the write word are a keep-mask and the lower 16 bits are new data. This lets software set or clear single pins in one bus write, with no read-modify-write. With the default parameters, the pins numbered 54 to 63 (bank 1, bits 22 to 31) do not exist. Their register bits read as zero and ignore writes.

The bus side is a plain register port: a write strobe, a read strobe, a byte address and 32-bit data. The port has no handshake, so the master can issue a read or a write on every cycle. Read data comes from a register one cycle after the read strobe and holds until the next read.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the output data, direction and output-enable registers of every bank read as zero, and `gpio_out` and `gpio_oe` are all zero.
- R2: A write to byte offset 0x40+4*b replaces the output data of bank b. Reading that offset returns the value, and `gpio_out[32*b+31:32*b]` shows it from the cycle after the write.
- R3: A write to byte offset 8*b (low maskable register) updates bits 15:0 of bank b's output data. For each i in 0..15, bit i takes write bit i when write bit 16+i is 0, and keeps its value when write bit 16+i is 1. Bits 31:16 of the output data are unchanged.
- R4: A write to byte offset 4+8*b (high maskable register) applies the same rule to bits 31:16 of bank b's output data, with mask bit 16+i and data bit i selecting output bit 16+i. Bits 15:0 are unchanged.
- R5: Reading a maskable register returns the current output data of its half in bits 15:0, and zero in bits 31:16.
- R6: The direction register (offset 0x204+0x40*b) and the output-enable register (offset 0x208+0x40*b) read back as written. `gpio_oe` bit p is 1 exactly when both the direction bit and the output-enable bit of pin p are 1.
- R7: Reading offset 0x60+4*b returns the levels of bank b's input pins after a two-flop synchronizer. A level applied before clock edge k is returned by a read strobe sampled at edge k+2, and not by one sampled at edge k+1.
- R8: Pins below 54 and from 64 upward exist. The bits of pins 54 to 63 read as zero in every register, including the input register, ignore writes, and are never driven.
- R9: A write to an unmapped or misaligned offset, or to an input register, changes no state. A read from an unmapped or misaligned offset returns zero.
- R10: `rdata` is loaded at the clock edge that samples `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe, one read per cycle |
| addr | input | 12 | Byte address shared by reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| gpio_in | input | 128 | Pin input levels, asynchronous |
| gpio_out | output | 128 | Output data toward the pads |
| gpio_oe | output | 128 | Pad drive enable |

## Verification
Each result has a fixed due time. A write shows on `gpio_out` and `gpio_oe` after the same rising edge that samples `wr_en`. Read data shows after the edge that samples `rd_en`. An input level needs two more edges before a read can return it. The bench drives every strobe and sample on falling edges, so each check looks at exactly one rising edge's worth of effect. For the input path, it reads once one edge too early (expecting the old level) and once exactly on time (expecting the new level). A sweep over every word address, with expected values computed from the address arithmetic, covers the unmapped holes and the absent pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_W = 32;
  localparam int HALF_W = BANK_W / 2;

  // register map geometry (byte offsets)
  localparam int MSK_STRIDE  = 8;
  localparam int DOUT_BASE   = 'h40;
  localparam int DIN_BASE    = 'h60;
  localparam int WORD_STRIDE = 4;
  localparam int CFG_BASE    = 'h200;
  localparam int CFG_STRIDE  = 'h40;
  localparam int CFG_DIR_OFF = 4;
  localparam int CFG_OEN_OFF = 8;

  typedef enum logic [2:0] {
    K_NONE, K_MLO, K_MHI, K_DOUT, K_DIN, K_DIR, K_OEN
  } reg_kind_e;

  function automatic logic [BANK_W-1:0] pin_exist_mask(input int bank,
                                                       input int low_pins,
                                                       input int high_base);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < BANK_W; i++) begin
      int p;
      p = bank * BANK_W + i;
      m[i] = (p < low_pins) || (p >= high_base);
    end
    return m;
  endfunction

  function automatic logic [HALF_W-1:0] merge_half(input logic [HALF_W-1:0] cur,
                                                   input logic [BANK_W-1:0] wd);
    return (cur & wd[BANK_W-1:HALF_W]) | (wd[HALF_W-1:0] & ~wd[BANK_W-1:HALF_W]);
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int BIDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BIDX_W-1:0] bank
);
  always_comb begin
    int unsigned a;
    int unsigned off;
    a    = 32'(addr);
    off  = 0;
    kind = K_NONE;
    bank = '0;
    if (a[1:0] == 2'b00) begin
      if (a < MSK_STRIDE * NUM_BANKS) begin
        bank = BIDX_W'(a / MSK_STRIDE);
        kind = ((a % MSK_STRIDE) == 0) ? K_MLO : K_MHI;
      end else if (a >= DOUT_BASE && a < DOUT_BASE + WORD_STRIDE * NUM_BANKS) begin
        bank = BIDX_W'((a - DOUT_BASE) / WORD_STRIDE);
        kind = K_DOUT;
      end else if (a >= DIN_BASE && a < DIN_BASE + WORD_STRIDE * NUM_BANKS) begin
        bank = BIDX_W'((a - DIN_BASE) / WORD_STRIDE);
        kind = K_DIN;
      end else if (a >= CFG_BASE && a < CFG_BASE + CFG_STRIDE * NUM_BANKS) begin
        off  = a - CFG_BASE;
        bank = BIDX_W'(off / CFG_STRIDE);
        if ((off % CFG_STRIDE) == CFG_DIR_OFF)      kind = K_DIR;
        else if ((off % CFG_STRIDE) == CFG_OEN_OFF) kind = K_OEN;
      end
    end
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] EXIST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  reg_kind_e         wr_kind,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] data_q,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] oen_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      oen_q  <= '0;
    end else if (wr_hit) begin
      case (wr_kind)
        K_DOUT: data_q <= wdata & EXIST;
        K_MLO:  data_q[HALF_W-1:0] <= merge_half(data_q[HALF_W-1:0], wdata)
                                      & EXIST[HALF_W-1:0];
        K_MHI:  data_q[BANK_W-1:HALF_W] <= merge_half(data_q[BANK_W-1:HALF_W], wdata)
                                           & EXIST[BANK_W-1:HALF_W];
        K_DIR:  dir_q <= wdata & EXIST;
        K_OEN:  oen_q <= wdata & EXIST;
        default: ;
      endcase
    end
  end

  // R3
  lo_write_keeps_high_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_kind == K_MLO) |=> $stable(data_q[BANK_W-1:HALF_W]));

  // R3
  lo_write_unmasked_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_kind == K_MLO) |=>
      (((data_q[HALF_W-1:0] ^ $past(wdata[HALF_W-1:0])) & ~$past(wdata[BANK_W-1:HALF_W])
        & EXIST[HALF_W-1:0]) == '0));

  // R4
  hi_write_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_kind == K_MHI) |=> $stable(data_q[HALF_W-1:0]));

  // R8
  absent_pin_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((data_q | dir_q | oen_q) & ~EXIST) == '0);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int LOW_PINS  = 54,
  parameter int HIGH_BASE = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  output logic [BANK_W-1:0]           rdata,
  input  logic [NUM_BANKS*BANK_W-1:0] gpio_in,
  output logic [NUM_BANKS*BANK_W-1:0] gpio_out,
  output logic [NUM_BANKS*BANK_W-1:0] gpio_oe
);
  localparam int PINS   = NUM_BANKS * BANK_W;
  localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [BANK_W-1:0] EX0 = pin_exist_mask(0, LOW_PINS, HIGH_BASE);

  reg_kind_e         dec_kind;
  logic [BIDX_W-1:0] dec_bank;
  logic [PINS-1:0]   sync_q;
  logic [BANK_W-1:0] dout_q [NUM_BANKS];
  logic [BANK_W-1:0] dir_q  [NUM_BANKS];
  logic [BANK_W-1:0] oen_q  [NUM_BANKS];
  logic [BANK_W-1:0] din_q  [NUM_BANKS];
  logic [BANK_W-1:0] rd_mux;

  gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BIDX_W(BIDX_W)) u_dec (
    .addr(addr), .kind(dec_kind), .bank(dec_bank)
  );

  gpio_sync2 #(.WIDTH(PINS)) u_sync (
    .clk(clk), .rst(rst), .d(gpio_in), .q(sync_q)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [BANK_W-1:0] EX = pin_exist_mask(g, LOW_PINS, HIGH_BASE);
    logic hit;
    assign hit = wr_en && (dec_kind != K_NONE) && (dec_bank == BIDX_W'(g));

    gpio_bank_regs #(.EXIST(EX)) u_regs (
      .clk(clk), .rst(rst), .wr_hit(hit), .wr_kind(dec_kind), .wdata(wdata),
      .data_q(dout_q[g]), .dir_q(dir_q[g]), .oen_q(oen_q[g])
    );

    assign din_q[g]                       = sync_q[g*BANK_W +: BANK_W] & EX;
    assign gpio_out[g*BANK_W +: BANK_W]   = dout_q[g];
    assign gpio_oe[g*BANK_W +: BANK_W]    = dir_q[g] & oen_q[g];
  end

  always_comb begin
    rd_mux = '0;
    case (dec_kind)
      K_MLO:  rd_mux = {{HALF_W{1'b0}}, dout_q[dec_bank][HALF_W-1:0]};
      K_MHI:  rd_mux = {{HALF_W{1'b0}}, dout_q[dec_bank][BANK_W-1:HALF_W]};
      K_DOUT: rd_mux = dout_q[dec_bank];
      K_DIN:  rd_mux = din_q[dec_bank];
      K_DIR:  rd_mux = dir_q[dec_bank];
      K_OEN:  rd_mux = oen_q[dec_bank];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // cycles since reset, saturating; only gates the input-latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                 warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R9
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (dec_kind == K_NONE || dec_kind == K_DIN)) |=>
      ($stable(gpio_out) && $stable(gpio_oe)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R5
  masked_read_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (dec_kind == K_MLO || dec_kind == K_MHI)) |=> (rdata[BANK_W-1:HALF_W] == '0));

  // R7
  input_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q == 2'd3 && rd_en && dec_kind == K_DIN && dec_bank == '0) |=>
      (rdata == ($past(gpio_in[BANK_W-1:0], 3) & EX0)));
endmodule

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
  localparam int NB = 4;
  localparam int AW = 12;
  localparam int P  = NB * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [P-1:0]  gpio_in = '0;
  logic [P-1:0]  gpio_out, gpio_oe;

  int total = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_data [NB];
  logic [31:0] m_dir  [NB];
  logic [31:0] m_oen  [NB];

  always #2 clk = ~clk;

  gpio_bank_ctrl i_gpio_bank_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe)
  );

  function automatic logic [31:0] ex(input int b);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      int p;
      p = b * 32 + i;
      m[i] = (p < 54) || (p >= 64);
    end
    return m;
  endfunction

  function automatic logic [P-1:0] exp_out();
    logic [P-1:0] v;
    for (int b = 0; b < NB; b++) v[b*32 +: 32] = m_data[b];
    return v;
  endfunction

  function automatic logic [P-1:0] exp_oe();
    logic [P-1:0] v;
    for (int b = 0; b < NB; b++) v[b*32 +: 32] = m_dir[b] & m_oen[b];
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    if (a % 4 != 0) return 32'h0;
    if (a < 8 * NB) return (a % 8 == 0) ? {16'h0, m_data[a/8][15:0]} : {16'h0, m_data[a/8][31:16]};
    if (a >= 'h40 && a < 'h40 + 4 * NB) return m_data[(a - 'h40) / 4];
    if (a >= 'h60 && a < 'h60 + 4 * NB) return gpio_in[((a - 'h60) / 4) * 32 +: 32] & ex((a - 'h60) / 4);
    if (a >= 'h200 && a < 'h200 + 'h40 * NB) begin
      int b, r;
      b = (a - 'h200) / 'h40;
      r = (a - 'h200) % 'h40;
      if (r == 4) return m_dir[b];
      if (r == 8) return m_oen[b];
    end
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [P-1:0] act, input logic [P-1:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic mwrite(input int b, input int hi, input logic [15:0] msk, input logic [15:0] d);
    logic [15:0] cur, nxt;
    wr(8 * b + 4 * hi, {msk, d});
    cur = hi ? m_data[b][31:16] : m_data[b][15:0];
    nxt = (cur & msk) | (d & ~msk);
    if (hi) m_data[b][31:16] = nxt & ex(b)[31:16];
    else    m_data[b][15:0]  = nxt & ex(b)[15:0];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, hold;
    for (int b = 0; b < NB; b++) begin m_data[b] = '0; m_dir[b] = '0; m_oen[b] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 gpio_out after reset", gpio_out, '0);
    chk("R1 gpio_oe after reset", gpio_oe, '0);
    for (int b = 0; b < NB; b++) begin
      rd('h40 + 4 * b, v);   chk("R1 data reset", v, 0);
      rd('h204 + 'h40 * b, v); chk("R1 dir reset", v, 0);
      rd('h208 + 'h40 * b, v); chk("R1 oen reset", v, 0);
    end

    // R2 / R8 full data writes
    for (int b = 0; b < NB; b++) begin
      wr('h40 + 4 * b, 32'hFFFF_FFFF);
      m_data[b] = ex(b);
      rd('h40 + 4 * b, v);
      chk("R8 data ones masked by pin existence", v, ex(b));
      wr('h40 + 4 * b, 32'hA5C3_0F69 ^ (32'h1111_1111 * b));
      m_data[b] = (32'hA5C3_0F69 ^ (32'h1111_1111 * b)) & ex(b);
      chk("R2 gpio_out after data write", gpio_out, exp_out());
      rd('h40 + 4 * b, v);
      chk("R2 data readback", v, m_data[b]);
    end

    // R3 / R4 / R5 masked writes sweep
    for (int b = 0; b < NB; b++) begin
      for (int hi = 0; hi < 2; hi++) begin
        for (int k = 0; k < 10; k++) begin
          logic [15:0] msk, d;
          msk = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : 16'(16'h5A3C >> k) ^ 16'(16'h1111 * k);
          d   = ~{msk[7:0], msk[15:8]} ^ 16'(k * 16'h0F0F);
          mwrite(b, hi, msk, d);
          chk(hi ? "R4 gpio_out after high masked write" : "R3 gpio_out after low masked write",
              gpio_out, exp_out());
          rd(8 * b + 4 * hi, v);
          chk("R5 masked register readback", v, hi ? {16'h0, m_data[b][31:16]} : {16'h0, m_data[b][15:0]});
        end
      end
      rd('h40 + 4 * b, v);
      chk("R3 R4 data after masked sweep", v, m_data[b]);
    end

    // R6 direction and output enable
    for (int b = 0; b < NB; b++) begin
      wr('h204 + 'h40 * b, 32'hF0F0_33CC ^ (32'h0101_0101 * b));
      m_dir[b] = (32'hF0F0_33CC ^ (32'h0101_0101 * b)) & ex(b);
      wr('h208 + 'h40 * b, 32'hFF00_5A5A + b);
      m_oen[b] = (32'hFF00_5A5A + b) & ex(b);
      chk("R6 gpio_oe is dir and enable", gpio_oe, exp_oe());
      rd('h204 + 'h40 * b, v); chk("R6 dir readback", v, m_dir[b]);
      rd('h208 + 'h40 * b, v); chk("R6 oen readback", v, m_oen[b]);
    end
    wr('h204 + 'h40, 32'hFFFF_FFFF); m_dir[1] = ex(1);
    wr('h208 + 'h40, 32'hFFFF_FFFF); m_oen[1] = ex(1);
    chk("R8 absent pins never driven", gpio_oe, exp_oe());

    // R7 input synchronizer latency
    @(negedge clk); gpio_in = {P{1'b1}};
    @(negedge clk); @(negedge clk); @(negedge clk);
    rd('h60, v); chk("R7 input settled", v, 32'hFFFF_FFFF);
    rd('h64, v); chk("R8 input absent bits read zero", v, ex(1));
    @(negedge clk); gpio_in[31:0] = 32'h1234_5678;
    rd('h60, v); chk("R7 input not visible at second edge", v, 32'hFFFF_FFFF);
    @(negedge clk); gpio_in[31:0] = 32'h9ABC_DEF0;
    @(negedge clk);
    rd('h60, v); chk("R7 input visible at third edge", v, 32'h9ABC_DEF0);

    // R9 ignored writes
    wr('h100, 32'hFFFF_FFFF);
    wr('h20C, 32'hFFFF_FFFF);
    wr('h3FC, 32'h0);
    wr('h60, 32'h0);
    wr('h42, 32'h0);
    wr('h205, 32'hFFFF_FFFF);
    chk("R9 gpio_out unchanged after ignored writes", gpio_out, exp_out());
    chk("R9 gpio_oe unchanged after ignored writes", gpio_oe, exp_oe());
    rd('h42, v); chk("R9 misaligned read zero", v, 0);

    // R10 rdata holds while rd_en low
    rd('h40, hold);
    wr('h40, ~m_data[0]); m_data[0] = ~m_data[0] & ex(0);
    repeat (3) @(negedge clk);
    chk("R10 rdata held without read", rdata, hold);

    // R9 / R5 / R8 sweep of all word addresses
    @(negedge clk); gpio_in = {4{32'hC0DE_B00F}} ^ {32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0};
    repeat (3) @(negedge clk);
    for (int a = 0; a < (1 << AW); a += 4) begin
      rd(a, v);
      total++;
      if (v !== exp_read(a)) begin
        fails++;
        $display("FAIL R9 sweep addr %h: actual %h expected %h", a, v, exp_read(a));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule